// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

This block routes one pad out of a wide GPIO pad bus onto each of a small set of interrupt channels (eight by default). Each channel has its own pad selector and trigger configuration. The result is always an active-high signal: a level for level triggers, a one-cycle pulse for edge triggers. A downstream interrupt controller that only understands high levels and rising edges can therefore serve low-level, falling-edge and both-edge requests as well.

Pads pass through a two-flop synchronizer before selection. Inversion is applied to the selected pad when the low-polarity bit is set. A both-edge bit per channel overrides the single-edge and polarity bits. A global enable gates every channel. Software programs the block through four 32-bit word registers on a simple write-strobe bus with combinational read data: trigger control, two pad-select words and a filter-select word.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset all four registers read 0 and every irq_o bit is 0.
- R2: Word 0 keeps only bits [7:0] (edge enable for channel c at bit c), [15:8] (both-edge for channel c at bit 8+c), [23:16] (low polarity for channel c at bit 16+c) and [31] (global enable). All other bits read 0, so writing all ones reads back 0x80FFFFFF. Words 1 and 2 read back as written.
- R3: The pad index of channel c is the 8-bit field at bit (c mod 4)*8 of word 1 for c < 4, and of word 2 for c >= 4.
- R4: With the edge, low and both bits clear, irq_o[c] equals the selected pad. A pad change becomes visible at irq_o after the third rising clock edge.
- R5: With only the low bit set, irq_o[c] is high while the selected pad is low.
- R6: With only the edge bit set, a rising pad edge gives a one-cycle pulse on irq_o[c]. A falling edge gives nothing.
- R7: With the edge and low bits both set, a falling pad edge gives a one-cycle pulse. A rising edge gives nothing.
- R8: With the both-edge bit set, each pad transition gives a one-cycle pulse, whatever the edge and low bits hold.
- R9: While the global enable bit is 0, every irq_o bit is 0 one cycle later. Setting the bit releases level outputs on the next cycle.
- R10: A pad index at or above the number of implemented pads reads as constant 0, which is then subject to the channel's inversion.
- R11: In the cycle after any change of a channel's configuration, no edge pulse is produced for that channel, so changing the select or polarity creates no false edge.
- R12: Word 3 stores eight 4-bit filter-select fields (channel c at bit 4c), reads back as written and does not affect irq_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pad_i | input | NUM_PADS | Asynchronous GPIO pad levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word index (0 trigger, 1 select 0-3, 2 select 4-7, 3 filter) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word |
| irq_o | output | NUM_CH | Active-high channel interrupt outputs |

## Verification
Two channels may select the same pad with different triggers and fire in the same cycle. The bench provokes this by pointing channel 2 (both-edge) and channel 6 (rising) at one pad. On the rising transition it expects both pulses together, and on the falling transition only channel 2. A configuration write can also coincide with the cycle in which the newly selected or newly inverted pad looks like an edge. The bench judges this by checking that irq_o stays low for several cycles after each such write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PAD_SEL_W = 8;
  localparam int PAD_SPACE = 1 << PAD_SEL_W;

  localparam logic [1:0] W_TRIG  = 2'd0;
  localparam logic [1:0] W_SEL_A = 2'd1;
  localparam logic [1:0] W_SEL_B = 2'd2;
  localparam logic [1:0] W_FILT  = 2'd3;

  typedef struct packed {
    logic [PAD_SEL_W-1:0] sel;
    logic                 edge_md;
    logic                 low_md;
    logic                 both_md;
  } chan_cfg_t;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter bit HAS_BOTH = 1'b1,
  parameter bit HAS_GEN  = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [1:0]               addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  output chan_cfg_t [NUM_CH-1:0]   cfg_o,
  output logic                     gen_o
);
  function automatic logic [31:0] trig_mask();
    logic [31:0] m = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      m[i]      = 1'b1;
      m[16 + i] = 1'b1;
      if (HAS_BOTH) m[8 + i] = 1'b1;
    end
    if (HAS_GEN) m[31] = 1'b1;
    return m;
  endfunction

  localparam logic [31:0] TRIG_MASK = trig_mask();

  logic [31:0]      trig_q;
  logic [1:0][31:0] psel_q;
  logic [31:0]      filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      psel_q <= '0;
      filt_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        W_TRIG:  trig_q    <= wdata_i & TRIG_MASK;
        W_SEL_A: psel_q[0] <= wdata_i;
        W_SEL_B: psel_q[1] <= wdata_i;
        default: filt_q    <= wdata_i;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      W_TRIG:  rdata_o = trig_q;
      W_SEL_A: rdata_o = psel_q[0];
      W_SEL_B: rdata_o = psel_q[1];
      default: rdata_o = filt_q;
    endcase
  end

  assign gen_o = HAS_GEN ? trig_q[31] : 1'b1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    assign cfg_o[c].sel     = psel_q[c / 4][(c % 4) * PAD_SEL_W +: PAD_SEL_W];
    assign cfg_o[c].edge_md = trig_q[c];
    assign cfg_o[c].low_md  = trig_q[16 + c];
    assign cfg_o[c].both_md = trig_q[8 + c];
  end
endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
  import gpio_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PAD_SPACE-1:0] pad_i,
  input  chan_cfg_t            cfg_i,
  input  logic                 gen_i,
  output logic                 irq_o
);
  chan_cfg_t cfg_q;
  logic      sig, prev_q, cfg_chg, pulse, irq_d;

  // both-edge ignores polarity
  assign sig     = pad_i[cfg_i.sel] ^ (cfg_i.low_md & ~cfg_i.both_md);
  assign cfg_chg = (cfg_i != cfg_q);
  assign pulse   = cfg_i.both_md ? (sig ^ prev_q) : (sig & ~prev_q);
  assign irq_d   = gen_i & ((cfg_i.both_md | cfg_i.edge_md) ? (pulse & ~cfg_chg) : sig);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cfg_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      prev_q <= sig;
      cfg_q  <= cfg_i;
      irq_o  <= irq_d;
    end
  end
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS = 200,
  parameter int NUM_CH   = 8,
  parameter bit HAS_BOTH = 1'b1,
  parameter bit HAS_GEN  = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] pad_i,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_CH-1:0]   irq_o
);
  logic [NUM_PADS-1:0]     sync1_q, sync2_q;
  logic [PAD_SPACE-1:0]    pad_ext;
  chan_cfg_t [NUM_CH-1:0]  chan_cfg;
  logic                    gen_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_i;
      sync2_q <= sync1_q;
    end
  end

  // unimplemented pad indices read as 0
  assign pad_ext = PAD_SPACE'(sync2_q);

  gpio_irq_regs #(
    .NUM_CH  (NUM_CH),
    .HAS_BOTH(HAS_BOTH),
    .HAS_GEN (HAS_GEN)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .cfg_o  (chan_cfg),
    .gen_o  (gen_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    gpio_irq_chan u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pad_i (pad_ext),
      .cfg_i (chan_cfg[c]),
      .gen_i (gen_en),
      .irq_o (irq_o[c])
    );
  end
endmodule

// File: rtl/gpio_irq_mux_sva.sv
module gpio_irq_mux_sva
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS = 200,
  parameter int NUM_CH   = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_CH-1:0]      irq_i,
  input logic                   gen_i,
  input chan_cfg_t [NUM_CH-1:0] cfg_i
);
  localparam logic [PAD_SEL_W:0] PAD_LIM = (PAD_SEL_W + 1)'(NUM_PADS);

  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_i |=> (irq_i == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_i[c] && cfg_i[c].edge_md && !cfg_i[c].both_md) |=> !irq_i[c]);

    p_suppress_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(cfg_i[c]) && (cfg_i[c].edge_md || cfg_i[c].both_md)) |=> !irq_i[c]);

    p_oor_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (({1'b0, cfg_i[c].sel} >= PAD_LIM) && !cfg_i[c].edge_md &&
       !cfg_i[c].low_md && !cfg_i[c].both_md) |=> !irq_i[c]);
  end
endmodule

bind gpio_irq_mux gpio_irq_mux_sva #(
  .NUM_PADS(NUM_PADS),
  .NUM_CH  (NUM_CH)
) u_sva (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .irq_i (irq_o),
  .gen_i (gen_en),
  .cfg_i (chan_cfg)
);

// File: tb/gpio_irq_mux_tb_top.sv
`timescale 1ns/100ps
module gpio_irq_mux_tb_top;
  localparam int NP = 200;
  localparam int NC = 8;
  localparam logic [31:0] GEN = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pad = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] irq;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_mux dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pad), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #0.5;
    check(req, rdata, exp);
  endtask

  task automatic clear_all();
    wr(2'd0, 32'h0); wr(2'd1, 32'h0); wr(2'd2, 32'h0); wr(2'd3, 32'h0);
    pad = '0;
    tick(4);
  endtask

  task automatic t_reset();
    tick(2);
    check("R1 irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    tick(2);
    check("R1 irq after reset", 32'(irq), 32'h0);
    for (int a = 0; a < 4; a++) rd_chk("R1 reg reset", 2'(a), 32'h0);
  endtask

  task automatic t_regs();
    wr(2'd0, 32'hFFFF_FFFF);
    rd_chk("R2 trig mask", 2'd0, 32'h80FF_FFFF);
    wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'h9ABC_DEF0);
    rd_chk("R2 sel word 1", 2'd1, 32'h1234_5678);
    rd_chk("R2 sel word 2", 2'd2, 32'h9ABC_DEF0);
    clear_all();
  endtask

  task automatic t_level();
    wr(2'd1, 32'h000A_0000);           // ch2 <- pad 10
    wr(2'd2, 32'h0000_2100);           // ch5 <- pad 33
    wr(2'd0, GEN);
    tick(3);
    pad[10] = 1'b1;
    tick(2);
    check("R4 latency before third edge", 32'(irq), 32'h0);
    tick(1);
    check("R4 level high ch2 (R3 word 1)", 32'(irq), 32'h04);
    pad[33] = 1'b1;
    tick(3);
    check("R3 ch5 via word 2", 32'(irq), 32'h24);
    pad = '0;
    tick(3);
    check("R4 level drops", 32'(irq), 32'h0);
    wr(2'd0, GEN | 32'h0004_0000);     // ch2 low level
    tick(3);
    check("R5 low level pad low", 32'(irq), 32'h04);
    pad[10] = 1'b1;
    tick(3);
    check("R5 low level pad high", 32'(irq), 32'h0);
    clear_all();
  endtask

  task automatic t_rise_fall();
    wr(2'd1, 32'h000A_0000);
    wr(2'd0, GEN | 32'h0000_0004);     // ch2 rising
    tick(4);
    pad[10] = 1'b1;
    tick(3);
    check("R6 rising pulse", 32'(irq), 32'h04);
    tick(1);
    check("R6 pulse one cycle", 32'(irq), 32'h0);
    pad[10] = 1'b0;
    tick(3);
    check("R6 no pulse on fall", 32'(irq), 32'h0);
    tick(1);
    check("R6 no pulse on fall late", 32'(irq), 32'h0);
    wr(2'd0, GEN | 32'h0004_0004);     // ch2 falling
    tick(4);
    pad[10] = 1'b1;
    tick(3);
    check("R7 no pulse on rise", 32'(irq), 32'h0);
    tick(2);
    pad[10] = 1'b0;
    tick(3);
    check("R7 falling pulse", 32'(irq), 32'h04);
    tick(1);
    check("R7 pulse one cycle", 32'(irq), 32'h0);
    clear_all();
  endtask

  task automatic t_both();
    wr(2'd1, 32'h000A_0000);           // ch2 <- pad 10
    wr(2'd2, 32'h000A_0000);           // ch6 <- pad 10
    wr(2'd0, GEN | 32'h0004_0444);     // ch2 both (+edge+low overridden), ch6 rising
    tick(4);
    pad[10] = 1'b1;
    tick(3);
    check("R8 both-edge rise with ch6 rising", 32'(irq), 32'h44);
    tick(1);
    check("R8 pulses one cycle", 32'(irq), 32'h0);
    pad[10] = 1'b0;
    tick(3);
    check("R8 both-edge fall", 32'(irq), 32'h04);
    tick(1);
    check("R8 fall pulse one cycle", 32'(irq), 32'h0);
    clear_all();
  endtask

  task automatic t_gate();
    wr(2'd1, 32'h000A_0000);
    pad[10] = 1'b1;
    tick(4);
    check("R9 gated without enable", 32'(irq), 32'h0);
    wr(2'd0, GEN);
    tick(1);
    check("R9 released next cycle", 32'(irq), 32'h04);
    wr(2'd0, 32'h0);
    tick(1);
    check("R9 gated again", 32'(irq), 32'h0);
    clear_all();
  endtask

  task automatic t_oor();
    pad = '1;
    wr(2'd1, 32'h00FA_0000);           // ch2 <- 250
    wr(2'd0, GEN);
    tick(4);
    check("R10 out-of-range reads 0", 32'(irq[2]), 32'h0);
    wr(2'd0, GEN | 32'h0004_0000);
    tick(3);
    check("R10 inverted out-of-range", 32'(irq[2]), 32'h1);
    wr(2'd0, GEN);
    wr(2'd1, 32'h00C7_0000);           // ch2 <- 199
    tick(3);
    check("R10 last valid pad", 32'(irq[2]), 32'h1);
    pad[199] = 1'b0;
    tick(3);
    check("R10 last valid pad low", 32'(irq[2]), 32'h0);
    clear_all();
  endtask

  task automatic t_chg();
    wr(2'd1, 32'h000A_0000);
    wr(2'd0, GEN | 32'h0000_0004);     // ch2 rising
    tick(4);
    wr(2'd0, GEN | 32'h0004_0004);     // invert while pad low
    for (int i = 0; i < 4; i++) begin
      check("R11 no pulse on polarity change", 32'(irq), 32'h0);
      tick(1);
    end
    wr(2'd0, GEN | 32'h0000_0004);
    pad[11] = 1'b1;
    tick(4);
    wr(2'd1, 32'h000B_0000);           // switch to high pad 11
    for (int i = 0; i < 4; i++) begin
      check("R11 no pulse on select change", 32'(irq), 32'h0);
      tick(1);
    end
    pad[11] = 1'b0;
    tick(4);
    pad[11] = 1'b1;
    tick(3);
    check("R11 edges work after change", 32'(irq), 32'h04);
    clear_all();
  endtask

  task automatic t_filter();
    wr(2'd1, 32'h000A_0000);
    wr(2'd0, GEN);
    pad[10] = 1'b1;
    tick(3);
    wr(2'd3, 32'hA5A5_5A5A);
    for (int i = 0; i < 3; i++) begin
      check("R12 filter write no effect", 32'(irq), 32'h04);
      tick(1);
    end
    rd_chk("R12 filter readback", 2'd3, 32'hA5A5_5A5A);
    clear_all();
  endtask

  initial begin
    t_reset();
    t_regs();
    t_level();
    t_rise_fall();
    t_both();
    t_gate();
    t_oor();
    t_chg();
    t_filter();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule